// File: doc/BRIEF.md
# Per-Channel Thermal Shutdown Arbiter

This block decides which regulator channels are switched off when the die overheats. It watches a digitized die-temperature code and keeps an overheat state with hysteresis. The state is entered when the code reaches a high trip threshold. It is left only when the code drops below a lower release threshold. Each channel reports whether it is heavily loaded, meaning it sources more than about 50 mA. On overheat, only the heavily loaded channels that are enabled are forced off. Lightly loaded channels keep running.

The disabled set is captured when overheat is declared and held until the die cools. A channel that becomes heavily loaded while the die is still hot joins the set. When the temperature falls below the release threshold, every channel in the set is freed at once. Each freed channel gets a one-cycle restart pulse, which its regulator uses to run its soft-start again. A channel whose own enable is low is never held off and never receives a restart pulse.

Top module: `thermal_shutdown_arb`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `therm_off` and `restart_pulse` are all zero.
- R2: When `temp_code` is at or above HOT_CODE (default 145) and the block is not in overheat, then on the next clock edge `therm_off` becomes the bitwise AND of `ch_enable` and `heavy_load` (bit i is channel i).
- R3: A channel whose `heavy_load` bit is 0 when overheat is declared keeps its `therm_off` bit at 0. This holds even when no channel is heavy.
- R4: If every enabled channel is heavy when overheat is declared, every enabled channel is disabled.
- R5: During overheat, a disabled channel stays disabled while its enable is high, even if its load drops or the temperature falls into the band between the two thresholds.
- R6: During overheat, an enabled channel whose `heavy_load` rises is disabled on the next clock edge.
- R7: Hysteresis: overheat ends only when `temp_code` is below COOL_CODE (default 110). A code of exactly COOL_CODE keeps overheat. A code below HOT_CODE does not start overheat.
- R8: When overheat ends, all `therm_off` bits clear on the next edge. At the same edge, `restart_pulse` goes high for exactly one cycle on each channel that was disabled and is still enabled.
- R9: A channel with `ch_enable` low has `therm_off` 0 on the next edge and receives no restart pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_code | input | TEMP_W | Digitized die temperature, one code per degree |
| heavy_load | input | NUM_CH | Per-channel flag: channel sources more than about 50 mA |
| ch_enable | input | NUM_CH | Per-channel regulator enable |
| therm_off | output | NUM_CH | Per-channel thermal disable, registered |
| restart_pulse | output | NUM_CH | Per-channel one-cycle soft-start restart request, registered |

## Verification
The assertions check several properties on every cycle. A channel may only turn off if it was heavy one cycle earlier. It may only stay off while enabled. Release happens only on a cool-down or a dropped enable. Restart pulses last one cycle and follow a disabled channel. The overheat state changes only when the code sits on the proper side of the matching threshold. The bench scenarios are needed for the rest. They show the exact disabled set at a trip, the boundary codes 144/145 and 110/109, and latching across load changes. They also show a late-heavy channel being added, and the absence of a pulse for a channel dropped by its enable while hot.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

  // Trip test: the code has reached the high threshold.
  function automatic logic reaches_hot(input int unsigned code, input int unsigned hot_thr);
    return code >= hot_thr;
  endfunction

  // Release test: the code is strictly below the low threshold.
  function automatic logic under_cool(input int unsigned code, input int unsigned cool_thr);
    return code < cool_thr;
  endfunction

  // Overheat state for the next cycle.
  function automatic logic hot_after(input logic hot_now, input logic trip, input logic cool);
    return (hot_now & ~cool) | trip;
  endfunction

  // Channel disable for the next cycle.
  function automatic logic off_after(input logic en, input logic hot_next,
                                     input logic off_now, input logic heavy);
    return en & hot_next & (off_now | heavy);
  endfunction

endpackage

// File: rtl/tsd_hyst.sv
module tsd_hyst #(
  parameter int TEMP_W    = 8,
  parameter int HOT_CODE  = 145,
  parameter int COOL_CODE = 110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              hot_state,
  output logic              hot_next,
  output logic              trip_evt,
  output logic              cool_evt
);
  import tsd_pkg::*;

  localparam int unsigned HOT_U  = HOT_CODE;
  localparam int unsigned COOL_U = COOL_CODE;

  logic at_hot;
  logic below_cool;

  always_comb begin
    at_hot     = reaches_hot(int'(temp_code), HOT_U);
    below_cool = under_cool(int'(temp_code), COOL_U);
    trip_evt   = ~hot_state & at_hot;
    cool_evt   = hot_state & below_cool;
    hot_next   = hot_after(hot_state, trip_evt, cool_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot_state <= 1'b0;
    else        hot_state <= hot_next;
  end

endmodule

// File: rtl/tsd_chan.sv
module tsd_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic heavy,
  input  logic hot_next,
  input  logic cool_evt,
  output logic off_q,
  output logic restart_q
);
  import tsd_pkg::*;

  logic off_d;
  logic restart_d;

  always_comb begin
    off_d     = off_after(en, hot_next, off_q, heavy);
    restart_d = cool_evt & off_q & en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q     <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      off_q     <= off_d;
      restart_q <= restart_d;
    end
  end

endmodule

// File: rtl/thermal_shutdown_arb.sv
module thermal_shutdown_arb #(
  parameter int NUM_CH    = 2,
  parameter int TEMP_W    = 8,
  parameter int HOT_CODE  = 145,
  parameter int COOL_CODE = 110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [NUM_CH-1:0] heavy_load,
  input  logic [NUM_CH-1:0] ch_enable,
  output logic [NUM_CH-1:0] therm_off,
  output logic [NUM_CH-1:0] restart_pulse
);

  // Internal events, brought out as named wires for the checker.
  logic hot_state;
  logic hot_next;
  logic trip_evt;
  logic cool_evt;

  tsd_hyst #(
    .TEMP_W   (TEMP_W),
    .HOT_CODE (HOT_CODE),
    .COOL_CODE(COOL_CODE)
  ) u_hyst (
    .clk      (clk),
    .rst_n    (rst_n),
    .temp_code(temp_code),
    .hot_state(hot_state),
    .hot_next (hot_next),
    .trip_evt (trip_evt),
    .cool_evt (cool_evt)
  );

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    tsd_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_enable[gi]),
      .heavy    (heavy_load[gi]),
      .hot_next (hot_next),
      .cool_evt (cool_evt),
      .off_q    (therm_off[gi]),
      .restart_q(restart_pulse[gi])
    );
  end

endmodule

// File: rtl/tsd_checker.sv
module tsd_checker #(
  parameter int NUM_CH    = 2,
  parameter int TEMP_W    = 8,
  parameter int HOT_CODE  = 145,
  parameter int COOL_CODE = 110
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TEMP_W-1:0] temp_code,
  input logic [NUM_CH-1:0] heavy_load,
  input logic [NUM_CH-1:0] ch_enable,
  input logic [NUM_CH-1:0] therm_off,
  input logic [NUM_CH-1:0] restart_pulse,
  input logic              hot_state
);
  localparam logic [TEMP_W-1:0] HOT_T  = HOT_CODE[TEMP_W-1:0];
  localparam logic [TEMP_W-1:0] COOL_T = COOL_CODE[TEMP_W-1:0];

  // R7: overheat starts only from a code at or above the trip level
  a_r7_trip_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot_state) |-> $past(temp_code) >= HOT_T);

  // R7: overheat ends only from a code below the release level
  a_r7_release_level: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hot_state) |-> $past(temp_code) < COOL_T);

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
    // R3/R6: a channel turns off only if it was heavy one cycle earlier
    a_r3_off_needs_heavy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(therm_off[gi]) |-> $past(heavy_load[gi]));

    // R9: a disabled channel never carries a thermal disable
    a_r9_off_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      therm_off[gi] |-> $past(ch_enable[gi]));

    // R5: release only by cool-down or dropped enable
    a_r5_hold_while_hot: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(therm_off[gi]) |-> (!hot_state || !$past(ch_enable[gi])));

    // R8: restart pulses are one cycle wide
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      restart_pulse[gi] |=> !restart_pulse[gi]);

    // R8: a pulse follows a disabled channel being released
    a_r8_pulse_after_off: assert property (@(posedge clk) disable iff (!rst_n)
      restart_pulse[gi] |-> ($past(therm_off[gi]) && !therm_off[gi] && !hot_state));
  end

endmodule

bind thermal_shutdown_arb tsd_checker #(
  .NUM_CH   (NUM_CH),
  .TEMP_W   (TEMP_W),
  .HOT_CODE (HOT_CODE),
  .COOL_CODE(COOL_CODE)
) u_tsd_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .temp_code    (temp_code),
  .heavy_load   (heavy_load),
  .ch_enable    (ch_enable),
  .therm_off    (therm_off),
  .restart_pulse(restart_pulse),
  .hot_state    (hot_state)
);

// File: tb/test_thermal_shutdown_arb.sv
module test_thermal_shutdown_arb;
  localparam int NC   = 2;
  localparam int TW   = 8;
  localparam int HOT  = 145;
  localparam int COOL = 110;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] temp_code = '0;
  logic [NC-1:0] heavy_load = '0;
  logic [NC-1:0] ch_enable = '0;
  logic [NC-1:0] therm_off;
  logic [NC-1:0] restart_pulse;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  typedef struct {
    logic [NC-1:0] off;
    logic [NC-1:0] rs;
    string         req;
  } exp_t;

  exp_t sb[$];

  // bench model state
  bit            m_hot = 1'b0;
  logic [NC-1:0] m_off = '0;

  always #4 clk = ~clk;

  thermal_shutdown_arb #(.NUM_CH(NC), .TEMP_W(TW), .HOT_CODE(HOT), .COOL_CODE(COOL))
    i_thermal_shutdown_arb (
      .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .heavy_load(heavy_load),
      .ch_enable(ch_enable), .therm_off(therm_off), .restart_pulse(restart_pulse));

  task automatic step(input int t, input logic [NC-1:0] hv, input logic [NC-1:0] en,
                      input string req);
    exp_t e;
    bit   releasing;
    bit   tripping;
    @(negedge clk);
    temp_code  = t[TW-1:0];
    heavy_load = hv;
    ch_enable  = en;
    releasing  = m_hot && (t <= COOL - 1);
    tripping   = !m_hot && (t > HOT - 1);
    for (int i = 0; i < NC; i++) begin
      e.rs[i] = 1'b0;
      if (en[i] == 1'b0) e.off[i] = 1'b0;
      else if (releasing) begin
        e.rs[i]  = m_off[i];
        e.off[i] = 1'b0;
      end else if (m_hot || tripping) e.off[i] = m_off[i] || hv[i];
      else e.off[i] = 1'b0;
    end
    if (releasing) m_hot = 1'b0;
    else if (tripping) m_hot = 1'b1;
    m_off = e.off;
    e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (therm_off !== e.off || restart_pulse !== e.rs) begin
          failures++;
          $display("FAIL %s off=%b rs=%b expected off=%b rs=%b",
                   e.req, therm_off, restart_pulse, e.off, e.rs);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (therm_off !== '0 || restart_pulse !== '0) begin
      failures++;
      $display("FAIL R1 off=%b rs=%b expected off=00 rs=00", therm_off, restart_pulse);
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(100, 2'b00, 2'b11, "R1 first cycle after reset");
    step(144, 2'b01, 2'b11, "R7 code 144 does not trip");
    step(145, 2'b01, 2'b11, "R2/R3 trip disables heavy ch0 only");
    step(120, 2'b00, 2'b11, "R5 latched while load drops");
    step(120, 2'b10, 2'b11, "R6 ch1 added when heavy");
    step(110, 2'b00, 2'b11, "R7 code 110 keeps overheat");
    step(109, 2'b00, 2'b11, "R8 release with restart pulses");
    step(109, 2'b00, 2'b11, "R8 pulse lasts one cycle");
    step(150, 2'b11, 2'b11, "R4 both heavy both disabled");
    step(150, 2'b11, 2'b10, "R9 dropped enable clears ch0");
    step(150, 2'b11, 2'b11, "R6 re-enabled heavy ch0 added");
    step(100, 2'b00, 2'b01, "R9 no pulse on ch1 with enable low");
    step(200, 2'b00, 2'b11, "R3 trip with no heavy channel");
    step(130, 2'b00, 2'b11, "R3 light channels stay on");
    step(100, 2'b00, 2'b11, "R8 no pulse when nothing was off");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule